// File: doc/BRIEF.md
# Window Watchdog with Glitch-Filtered Trigger Sampling

This block supervises a processor that must toggle a trigger input at a regular rate. It samples the trigger input on a slow tick taken from the system clock. A HIGH-to-LOW transition counts as a trigger only when two HIGH samples are followed directly by two LOW samples. When the processor misbehaves, the block pulls an active-low reset output LOW for a fixed time.

After the block is enabled, it first waits through an ignore window. It then opens a long first open window, which the first valid trigger ends. From then on it alternates between two windows. In a closed window any trigger is premature and causes a reset. In an open window a trigger must arrive before the window times out. A two-bit mode input selects fast timing, slow timing (all lengths scaled by a factor) or off. An enable input stands in for a load-current detector. While the block is off or disabled, the reset output stays HIGH. When it becomes active again, the sequence restarts from the ignore window.

Top module: `win_wdog`

## Requirements
- R1: While rst_ni is LOW, en_i is LOW or mode_i is 2'b00, sys_rst_no_o is HIGH one clock later and stays HIGH.
- R2: The trigger input passes through a two-flop synchronizer and is sampled once every SAMPLE_DIV clocks. The reset output changes only on a clock edge that carries a sample tick.
- R3: A trigger is decoded at the sample where the last four samples, oldest first, read 1,1,0,0. Any other sequence is not a trigger, including isolated one-sample HIGH pulses.
- R4: The decoder history is cleared after each decode. One pulse therefore yields exactly one trigger, however long its LOW phase lasts.
- R5: After activation, the ignore window lasts IGNORE_TICKS samples. Triggers decoded in it have no effect, and it never produces a reset.
- R6: The first open window lasts LONG_MULT*OPEN_TICKS samples. If no trigger arrives in it, the block enters reset, which happens (IGNORE_TICKS+LONG_MULT*OPEN_TICKS)*SAMPLE_DIV clocks after activation, within one sample period.
- R7: A trigger decoded in an open window starts a closed window at once. The closed window lasts CLOSED_TICKS samples and is followed by an open window of OPEN_TICKS samples.
- R8: A trigger decoded in a closed window, including on its last sample, forces reset.
- R9: If no trigger is decoded by the last sample of an open window, the block enters reset. A trigger decoded on that last sample is accepted.
- R10: A trigger whose first three samples fall in the closed window and whose fourth falls on the first open sample is accepted and is not a pretrigger.
- R11: Reset holds sys_rst_no_o LOW for RESET_TICKS*SAMPLE_DIV clocks (times SLOW_MULT when slow), then restarts with the ignore window and the long first open window.
- R12: mode_i encoding: 2'b00 off, 2'b01 fast, 2'b10 and 2'b11 slow. Slow multiplies every window and the reset length by SLOW_MULT.
- R13: Deasserting en_i returns the block to idle. Reasserting it restarts with the ignore window followed by the long first open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Supervision enable (load present) |
| mode_i | input | 2 | Timing select: off, fast, slow |
| trig_i | input | 1 | Processor trigger input |
| sys_rst_no_o | output | 1 | Active-low reset to the processor |

## Verification
Two events can land on the same sample tick. One is the decode of a trigger's fourth sample. The other is a window boundary: either the last sample of an open window, where the timeout competes with acceptance, or the first sample after a closed window, where the straddling trigger must not be taken as a pretrigger. The bench lines up the trigger pulse using its own model's window position. It places the fourth sample exactly on that last or first sample, then one sample late. Each placement is judged by whether the reset output falls, and every clock is compared against the model.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
  typedef enum logic [2:0] {
    WS_IDLE, WS_IGNORE, WS_FIRST, WS_CLOSED, WS_OPEN, WS_RESET
  } wd_state_e;

  typedef enum logic [1:0] {
    MD_OFF = 2'b00, MD_FAST = 2'b01, MD_SLOW_A = 2'b10, MD_SLOW_B = 2'b11
  } wd_mode_e;

  function automatic logic mode_is_slow(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int SAMPLE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (SAMPLE_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(SAMPLE_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(SAMPLE_DIV - 1);
      logic [DIV_W-1:0] div_q;
      assign tick_o = (div_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + DIV_W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_trig_dec.sv
module wdog_trig_dec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_i,
  input  logic trig_i,
  output logic hit_o
);
  localparam logic [3:0] PATTERN = 4'b1100; // oldest sample in bit 3

  logic [SYNC_STAGES-1:0] sync_q;
  logic [3:0]             hist_q;
  logic [3:0]             window;
  logic                   smp;

  assign smp    = sync_q[SYNC_STAGES-1];
  assign window = {hist_q[2:0], smp};
  assign hit_o  = tick_i && active_i && (window == PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
  end

  // history cleared on every decode so one pulse is counted once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (!active_i) hist_q <= '0;
    else if (hit_o)     hist_q <= '0;
    else if (tick_i)    hist_q <= window;
  end
endmodule

// File: rtl/wdog_win_fsm.sv
module wdog_win_fsm
  import win_wdog_pkg::*;
#(
  parameter int IGNORE_TICKS = 16,
  parameter int OPEN_TICKS   = 64,
  parameter int CLOSED_TICKS = 48,
  parameter int RESET_TICKS  = 8,
  parameter int LONG_MULT    = 4,
  parameter int SLOW_MULT    = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      hit_i,
  input  logic      active_i,
  input  logic      slow_i,
  output wd_state_e state_o,
  output logic      rst_no
);
  localparam int FIRST_TICKS = OPEN_TICKS * LONG_MULT;
  localparam int M1 = (IGNORE_TICKS > FIRST_TICKS) ? IGNORE_TICKS : FIRST_TICKS;
  localparam int M2 = (CLOSED_TICKS > RESET_TICKS) ? CLOSED_TICKS : RESET_TICKS;
  localparam int MAX_LEN = ((M1 > M2) ? M1 : M2) * SLOW_MULT;
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] L_IGN_F = CNT_W'(IGNORE_TICKS);
  localparam logic [CNT_W-1:0] L_FST_F = CNT_W'(FIRST_TICKS);
  localparam logic [CNT_W-1:0] L_CLS_F = CNT_W'(CLOSED_TICKS);
  localparam logic [CNT_W-1:0] L_OPN_F = CNT_W'(OPEN_TICKS);
  localparam logic [CNT_W-1:0] L_RST_F = CNT_W'(RESET_TICKS);
  localparam logic [CNT_W-1:0] L_IGN_S = CNT_W'(IGNORE_TICKS * SLOW_MULT);
  localparam logic [CNT_W-1:0] L_FST_S = CNT_W'(FIRST_TICKS * SLOW_MULT);
  localparam logic [CNT_W-1:0] L_CLS_S = CNT_W'(CLOSED_TICKS * SLOW_MULT);
  localparam logic [CNT_W-1:0] L_OPN_S = CNT_W'(OPEN_TICKS * SLOW_MULT);
  localparam logic [CNT_W-1:0] L_RST_S = CNT_W'(RESET_TICKS * SLOW_MULT);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             last;

  always_comb begin
    unique case (state_q)
      WS_IGNORE: len = slow_i ? L_IGN_S : L_IGN_F;
      WS_FIRST:  len = slow_i ? L_FST_S : L_FST_F;
      WS_CLOSED: len = slow_i ? L_CLS_S : L_CLS_F;
      WS_OPEN:   len = slow_i ? L_OPN_S : L_OPN_F;
      WS_RESET:  len = slow_i ? L_RST_S : L_RST_F;
      default:   len = CNT_W'(1);
    endcase
  end

  assign last = (cnt_q >= len - CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!active_i) begin
      state_d = WS_IDLE;
      cnt_d   = '0;
    end else if (state_q == WS_IDLE) begin
      state_d = WS_IGNORE;
      cnt_d   = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + CNT_W'(1);
      unique case (state_q)
        WS_IGNORE: if (last) begin state_d = WS_FIRST; cnt_d = '0; end
        WS_FIRST, WS_OPEN: begin
          // accepted trigger wins over a timeout on the same sample
          if (hit_i)     begin state_d = WS_CLOSED; cnt_d = '0; end
          else if (last) begin state_d = WS_RESET;  cnt_d = '0; end
        end
        WS_CLOSED: begin
          if (hit_i)     begin state_d = WS_RESET; cnt_d = '0; end
          else if (last) begin state_d = WS_OPEN;  cnt_d = '0; end
        end
        WS_RESET:  if (last) begin state_d = WS_IGNORE; cnt_d = '0; end
        default: begin state_d = WS_IDLE; cnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign rst_no  = (state_q != WS_RESET);
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int SAMPLE_DIV   = 62500,
  parameter int IGNORE_TICKS = 16,
  parameter int OPEN_TICKS   = 64,
  parameter int CLOSED_TICKS = 48,
  parameter int RESET_TICKS  = 8,
  parameter int LONG_MULT    = 4,
  parameter int SLOW_MULT    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       trig_i,
  output logic       sys_rst_no_o
);
  logic      smp_tick, trig_hit, active, slow;
  wd_state_e win_state;

  assign active = en_i && (mode_i != MD_OFF);
  assign slow   = mode_is_slow(mode_i);

  wdog_tick_gen #(.SAMPLE_DIV(SAMPLE_DIV)) tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(smp_tick)
  );

  wdog_trig_dec #(.SYNC_STAGES(2)) dec_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (smp_tick),
    .active_i(active),
    .trig_i  (trig_i),
    .hit_o   (trig_hit)
  );

  wdog_win_fsm #(
    .IGNORE_TICKS(IGNORE_TICKS), .OPEN_TICKS(OPEN_TICKS),
    .CLOSED_TICKS(CLOSED_TICKS), .RESET_TICKS(RESET_TICKS),
    .LONG_MULT(LONG_MULT), .SLOW_MULT(SLOW_MULT)
  ) fsm_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (smp_tick),
    .hit_i   (trig_hit),
    .active_i(active),
    .slow_i  (slow),
    .state_o (win_state),
    .rst_no  (sys_rst_no_o)
  );
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk
  import win_wdog_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] mode_i,
  input logic       sys_rst_no_o,
  input logic       tick_i,
  input logic       hit_i,
  input wd_state_e  state_i
);
  logic act;
  assign act = en_i && (mode_i != 2'b00);

  // R1
  inactive_rst_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> sys_rst_no_o);
  // R2
  rst_fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_no_o) |-> $past(tick_i));
  // R3
  hit_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> tick_i);
  // R5
  ignore_no_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == WS_IGNORE) |=> sys_rst_no_o);
  // R7
  open_hit_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == WS_OPEN || state_i == WS_FIRST) && hit_i && act) |=> (state_i == WS_CLOSED));
  // R8
  pretrig_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == WS_CLOSED && hit_i && act) |=> !sys_rst_no_o);
endmodule

bind win_wdog win_wdog_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .mode_i      (mode_i),
  .sys_rst_no_o(sys_rst_no_o),
  .tick_i      (smp_tick),
  .hit_i       (trig_hit),
  .state_i     (win_state)
);

// File: tb/win_wdog_tb_top.sv
module win_wdog_tb_top;
  localparam int DIV = 4, IGN = 8, OPN = 10, CLS = 8, RST = 5, LNG = 4, SLW = 2;
  localparam int E_FAST = (IGN + LNG * OPN) * DIV;

  typedef enum int {M_IDLE, M_IGN, M_FST, M_CLS, M_OPN, M_RST} mst_e;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wdi = 1'b0;
  logic [1:0] mode = 2'b01;
  logic dut_rst_n;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit lo_seen = 0;

  // reference model state
  int pre, m_cnt;
  bit s1, s2, m_ticked;
  mst_e m_st;
  bit q[$];

  always #4 clk = ~clk;

  win_wdog #(
    .SAMPLE_DIV(DIV), .IGNORE_TICKS(IGN), .OPEN_TICKS(OPN), .CLOSED_TICKS(CLS),
    .RESET_TICKS(RST), .LONG_MULT(LNG), .SLOW_MULT(SLW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .trig_i(wdi),
    .sys_rst_no_o(dut_rst_n)
  );

  function automatic int mlen(mst_e s, bit slow);
    int b;
    case (s)
      M_IGN:   b = IGN;
      M_FST:   b = OPN * LNG;
      M_CLS:   b = CLS;
      M_OPN:   b = OPN;
      M_RST:   b = RST;
      default: b = 1;
    endcase
    return slow ? b * SLW : b;
  endfunction

  always @(posedge clk) begin
    bit tk, act, smp, hit, fin;
    if (!rst_n) begin
      pre = 0; s1 = 0; s2 = 0; q.delete(); m_st = M_IDLE; m_cnt = 0; m_ticked = 0;
    end else begin
      tk = (pre == DIV - 1);
      pre = tk ? 0 : pre + 1;
      act = en && (mode != 2'b00);
      smp = s2; s2 = s1; s1 = wdi;
      hit = 0;
      if (!act) q.delete();
      else if (tk) begin
        q.push_back(smp);
        if (q.size() > 4) void'(q.pop_front());
        if (q.size() == 4 && q[0] && q[1] && !q[2] && !q[3]) begin hit = 1; q.delete(); end
      end
      if (!act) begin m_st = M_IDLE; m_cnt = 0; end
      else if (m_st == M_IDLE) begin m_st = M_IGN; m_cnt = 0; end
      else if (tk) begin
        fin = (m_cnt + 1 >= mlen(m_st, mode[1]));
        m_cnt++;
        case (m_st)
          M_IGN: if (fin) begin m_st = M_FST; m_cnt = 0; end
          M_FST, M_OPN:
            if (hit) begin m_st = M_CLS; m_cnt = 0; end
            else if (fin) begin m_st = M_RST; m_cnt = 0; end
          M_CLS:
            if (hit) begin m_st = M_RST; m_cnt = 0; end
            else if (fin) begin m_st = M_OPN; m_cnt = 0; end
          M_RST: if (fin) begin m_st = M_IGN; m_cnt = 0; end
          default: ;
        endcase
      end
      m_ticked = tk;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  always @(negedge clk) begin
    bit exp;
    cyc++;
    exp = !rst_n || (m_st != M_RST);
    if (rst_n && !dut_rst_n) lo_seen = 1;
    checks++;
    if (dut_rst_n !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: sys_rst_no_o=%0b expected=%0b", cur_req, cyc, dut_rst_n, exp);
    end
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!m_ticked);
    end
  endtask

  task automatic wait_state(input mst_e s);
    do @(negedge clk); while (m_st != s);
  endtask

  // 3 HIGH then 3 LOW sample periods
  task automatic pulse();
    wdi = 1; wait_ticks(3); wdi = 0; wait_ticks(3);
  endtask

  // samples HIGH at window count c and c+1, LOW at c+2 and c+3
  task automatic drive_at(input mst_e s, input int c);
    do @(negedge clk); while (!(m_ticked && m_st == s && m_cnt == c));
    wdi = 1; wait_ticks(2); wdi = 0; wait_ticks(3);
  endtask

  task automatic measure_fall(output int n);
    n = 0;
    while (dut_rst_n && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (!dut_rst_n && n < 5000) begin @(negedge clk); n++; end
  endtask

  // disable, then enable and synchronise with a first trigger
  task automatic restart(input logic [1:0] md);
    en = 0; wdi = 0;
    repeat (12) @(negedge clk);
    chk(dut_rst_n === 1'b1, "R13 idle output high", dut_rst_n, 1);
    mode = md; en = 1;
    wait_state(M_FST);
    pulse();
  endtask

  initial begin
    int n;
    repeat (5) @(negedge clk);
    chk(dut_rst_n === 1'b1, "R1 output high in reset", dut_rst_n, 1);
    rst_n = 1;

    cur_req = "R1";
    lo_seen = 0;
    repeat (300) @(negedge clk);
    chk(!lo_seen, "R1 disabled stays high", lo_seen, 0);
    cur_req = "R12";
    mode = 2'b00; en = 1; lo_seen = 0;
    repeat (300) @(negedge clk);
    chk(!lo_seen, "R12 mode 00 is off", lo_seen, 0);

    // no trigger at all: long first window timeout
    cur_req = "R6";
    mode = 2'b01;
    measure_fall(n);
    chk(n >= E_FAST - DIV && n <= E_FAST + 2, "R6 first timeout", n, E_FAST);
    cur_req = "R11";
    measure_low(n);
    chk(n == RST * DIV, "R11 reset width fast", n, RST * DIV);
    measure_fall(n);
    chk(n == E_FAST, "R11 restart with ignore and long window", n, E_FAST);

    // normal periodic service
    cur_req = "R7";
    restart(2'b01);
    lo_seen = 0;
    for (int i = 0; i < 5; i++) begin wait_state(M_OPN); pulse(); end
    chk(!lo_seen, "R7 regular triggers keep output high", lo_seen, 0);

    cur_req = "R4";
    lo_seen = 0;
    wait_state(M_OPN);
    wdi = 1; wait_ticks(3); wdi = 0; wait_ticks(14);
    wait_state(M_OPN); pulse();
    chk(!lo_seen, "R4 long low counted once", lo_seen, 0);

    cur_req = "R9";
    lo_seen = 0;
    drive_at(M_OPN, OPN - 4);
    wait_state(M_OPN); pulse();
    chk(!lo_seen, "R9 trigger on last open sample accepted", lo_seen, 0);

    cur_req = "R10";
    lo_seen = 0;
    drive_at(M_CLS, CLS - 3);
    wait_state(M_OPN); pulse();
    chk(!lo_seen, "R10 straddling trigger accepted", lo_seen, 0);

    cur_req = "R8";
    lo_seen = 0;
    wait_state(M_CLS);
    pulse();
    wait_ticks(2);
    chk(lo_seen, "R8 pretrigger forces reset", lo_seen, 1);

    cur_req = "R9";
    restart(2'b01);
    lo_seen = 0;
    drive_at(M_OPN, OPN - 3);
    wait_ticks(1);
    chk(lo_seen, "R9 trigger one sample late", lo_seen, 1);

    cur_req = "R3";
    restart(2'b01);
    wait_state(M_OPN);
    lo_seen = 0;
    wdi = 1; wait_ticks(1); wdi = 0; wait_ticks(1);
    wdi = 1; wait_ticks(1); wdi = 0;
    wait_ticks(OPN);
    chk(lo_seen, "R3 single-sample glitches not a trigger", lo_seen, 1);

    cur_req = "R5";
    en = 0; wdi = 0;
    repeat (12) @(negedge clk);
    mode = 2'b01; en = 1; wdi = 1;
    repeat (3 * DIV) @(negedge clk);
    wdi = 0;
    n = 3 * DIV;
    begin
      int k;
      measure_fall(k);
      n += k;
    end
    chk(n >= E_FAST - DIV && n <= E_FAST + 2, "R5 trigger in ignore window ignored", n, E_FAST);

    cur_req = "R12";
    en = 0;
    repeat (12) @(negedge clk);
    mode = 2'b10; en = 1;
    measure_fall(n);
    chk(n >= SLW * E_FAST - DIV && n <= SLW * E_FAST + 2, "R12 slow first timeout", n, SLW * E_FAST);
    measure_low(n);
    chk(n == SLW * RST * DIV, "R12 slow reset width", n, SLW * RST * DIV);

    cur_req = "R13";
    mode = 2'b11;
    restart(2'b11);
    lo_seen = 0;
    for (int i = 0; i < 3; i++) begin wait_state(M_OPN); pulse(); end
    chk(!lo_seen, "R13 re-enabled slow service", lo_seen, 0);
    en = 0;
    repeat (3) @(negedge clk);
    chk(dut_rst_n === 1'b1, "R1 disable output high", dut_rst_n, 1);

    summary();
    $finish;
  end
endmodule